// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block is a small cache placed between an in-order processor port and a slow word memory. The memory answers each request through a request/ready handshake. Each line holds one 32-bit word. The line is selected directly by the word-address bits just above the two byte-offset bits, and the remaining upper bits form the tag. A read that finds a valid line with a matching tag returns its word combinationally, in the same cycle, without stalling.

A read that does not find its word raises the stall. The block then fetches the word from memory at the missing address and installs the word, tag and valid bit. After that it repeats the lookup with the address the processor is still holding. This second lookup hits, and the stall drops in that cycle. Fill data is never forwarded directly to the processor. Instruction fetches and data loads use this same path.

Every write goes to both the cache and memory. The write stores its word and tag into the indexed line without comparing tags and marks the line valid, which replaces whatever the line held before. The write is then sent to memory with its full address. There is no write buffer, so the processor stays stalled until memory acknowledges the write. While the controller is busy, the processor must keep its request inputs stable.

Top module: `wt_cache`

## Requirements
- R1: A synchronous reset clears every valid bit, so the first read of any address after reset is a miss that stalls and fetches from memory.
- R2: A read whose line is valid with a matching tag drops `cpu_stall` in the cycle it is presented, returns the stored word on `cpu_rdata` in that cycle, and starts no memory transaction.
- R3: A read miss holds `cpu_stall` high and issues one memory read (`mem_req`=1, `mem_we`=0) at the full word address. The request, address and direction stay stable until `mem_ready`.
- R4: When the memory read completes, the returned word, the upper address bits and the valid bit are written into the line. The held request is then looked up again, hits, and returns the memory word with the stall released.
- R5: A write stores its tag and word into the indexed line without a hit check and sets the valid bit. A later read of the same address hits with the new word, and a read of an older address that maps to the same line misses.
- R6: Every write, whether hit or miss, produces exactly one memory write (`mem_we`=1) carrying the full address and the write word.
- R7: A write keeps `cpu_stall` high from the cycle it is presented until the cycle in which `mem_ready` acknowledges the memory write.
- R8: No new processor request is accepted while a memory transaction is in progress. Each access produces at most one memory transaction, and `mem_req` drops in the cycle after `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Byte address (word aligned) |
| cpu_wdata | input | DW | Write word |
| cpu_rdata | output | DW | Read word, valid when a read is not stalled |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write word |
| mem_rdata | input | DW | Memory read word, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current transaction |

## Verification
The lookup is exercised with random reads and writes over a 4096-word space, which is four times the line count. Addresses are drawn from a small hot set, so that repeated reads separate hits from misses, and from the full space, so that different tags collide on the same line. Directed sequences cover reads right after reset (must miss), a write followed by a read of the same address (must hit without a tag check), and a write to an aliased address followed by a read of the evicted one (must miss and return the unchanged memory word). Memory latency varies randomly from zero to three wait cycles, which checks that the request is held and that the replayed hit releases the stall regardless of fill timing.

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LINES = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_stall,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW - 2;

  typedef enum logic [1:0] {S_IDLE, S_RD_WAIT, S_FILL, S_WR_WAIT} state_t;

  state_t         state;
  logic [DW-1:0]  data_q [LINES];
  logic [TW-1:0]  tag_q  [LINES];
  logic [LINES-1:0] valid_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [DW-1:0]  fill_q;

  wire [IW-1:0] idx      = cpu_addr[IW+1:2];
  wire [TW-1:0] tag      = cpu_addr[AW-1:IW+2];
  wire [IW-1:0] fill_idx = addr_q[IW+1:2];
  wire          idle     = (state == S_IDLE);
  wire          hit      = valid_q[idx] && (tag_q[idx] == tag);
  wire          take_wr  = idle && cpu_req && cpu_we;
  wire          take_rm  = idle && cpu_req && !cpu_we && !hit;

  assign cpu_rdata = data_q[idx];
  assign cpu_stall = idle ? (cpu_req && (cpu_we || !hit))
                          : ((state == S_WR_WAIT) ? !mem_ready : 1'b1);
  assign mem_req   = (state == S_RD_WAIT) || (state == S_WR_WAIT);
  assign mem_we    = (state == S_WR_WAIT);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      fill_q  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (take_wr || take_rm) begin
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
            state   <= take_wr ? S_WR_WAIT : S_RD_WAIT;
          end
        end
        S_RD_WAIT: if (mem_ready) begin
          fill_q <= mem_rdata;
          state  <= S_FILL;
        end
        S_FILL:    state <= S_IDLE;
        S_WR_WAIT: if (mem_ready) state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (take_wr) valid_q[idx] <= 1'b1;
    else if (state == S_FILL) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take_wr) begin
      data_q[idx] <= cpu_wdata;
      tag_q[idx]  <= tag;
    end else if (state == S_FILL) begin
      data_q[fill_idx] <= fill_q;
      tag_q[fill_idx]  <= addr_q[AW-1:IW+2];
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_busy_stall_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |-> cpu_stall);

  assert_replay_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_FILL) && cpu_req && !cpu_we |=>
      (cpu_addr[AW-1:2] != $past(addr_q[AW-1:2])) || !cpu_stall);

  assert_alloc_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_WR_WAIT) && (cpu_addr[AW-1:2] == mem_addr[AW-1:2]) |-> hit);

  assert_wt_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_we && !cpu_stall |-> mem_req && mem_we && mem_ready);

  assert_one_txn_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ready |=> !mem_req);
endmodule

// File: tb/wt_cache_bench.sv
module wt_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  wt_cache u_wt_cache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
  logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
  logic [31:0] membank [4096];
  logic [31:0] expmem  [4096];
  bit          mvalid  [1024];
  logic [1:0]  mtag    [1024];

  function automatic logic [31:0] init_word(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ready = 1'b1;
        if (mem_we) begin
          membank[mem_addr[13:2]] = mem_wdata;
          wr_cnt++; last_wr_addr = mem_addr; last_wr_data = mem_wdata;
        end else begin
          mem_rdata = membank[mem_addr[13:2]];
          rd_cnt++; last_rd_addr = mem_addr;
        end
        wait_cnt = $urandom_range(0, 3);
      end else wait_cnt--;
    end
  end

  task automatic access(input bit we, input logic [11:0] widx, input logic [31:0] wd);
    logic [31:0] a = {18'd0, widx, 2'b00};
    int rd0 = rd_cnt, wr0 = wr_cnt, cyc = 0;
    bit exp_hit = mvalid[widx[9:0]] && (mtag[widx[9:0]] == widx[11:10]);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    while (cpu_stall && cyc < 100) begin
      @(negedge clk); #1; cyc++;
    end
    if (!we) begin
      check(cpu_rdata == expmem[widx], "R4 read data", cpu_rdata, expmem[widx]);
      check((cyc == 0) == exp_hit, "R2 hit without stall", cyc, exp_hit);
      check(rd_cnt - rd0 == (exp_hit ? 0 : 1), "R3 one memory read per miss", rd_cnt - rd0, exp_hit ? 0 : 1);
      if (!exp_hit) check(last_rd_addr == a, "R3 miss address", last_rd_addr, a);
      mvalid[widx[9:0]] = 1'b1; mtag[widx[9:0]] = widx[11:10];
    end else begin
      check(wr_cnt - wr0 == 1, "R6 one memory write", wr_cnt - wr0, 1);
      check(last_wr_addr == a && last_wr_data == wd, "R6 write address/data", last_wr_data, wd);
      check(cyc >= 1, "R7 write stalls until ack", cyc, 1);
      check(rd_cnt == rd0, "R8 no read on write", rd_cnt - rd0, 0);
      expmem[widx] = wd; mvalid[widx[9:0]] = 1'b1; mtag[widx[9:0]] = widx[11:10];
    end
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk); cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog R8 actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] hot [8];
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin membank[i] = init_word(i); expmem[i] = init_word(i); end
    for (int i = 0; i < 1024; i++) begin mvalid[i] = 1'b0; mtag[i] = '0; end
    for (int i = 0; i < 8; i++) hot[i] = 12'($urandom_range(0, 4095));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check(!cpu_stall && !mem_req, "R1 idle after reset", {cpu_stall, mem_req}, 0);

    access(1'b0, 12'h005, '0);          // R1 cold miss
    access(1'b0, 12'h005, '0);          // R2 hit
    access(1'b1, 12'h405, 32'hCAFE_0001); // R5 aliasing write evicts
    access(1'b0, 12'h405, '0);          // R5 new word hits
    access(1'b0, 12'h005, '0);          // R5 evicted line misses
    go_idle();
    access(1'b1, 12'hABC, 32'h1234_5678); // R6 write miss allocates
    access(1'b0, 12'hABC, '0);          // R5 hit on written word

    for (int n = 0; n < 1500; n++) begin
      logic [11:0] w = ($urandom_range(0, 1) == 1) ? hot[$urandom_range(0, 7)] : 12'($urandom_range(0, 4095));
      access(($urandom_range(0, 3) == 0), w, $urandom());
      if ($urandom_range(0, 4) == 0) go_idle();
    end
    go_idle();
    repeat (2) @(negedge clk);
    check(!mem_req && !cpu_stall, "R8 quiet at end", {mem_req, cpu_stall}, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule